// File: doc/BRIEF.md
# Almost-Flag Offset Configuration Unit

This unit holds the two threshold distances a FIFO's flag logic compares against: the almost-empty offset, counted from the empty end, and the almost-full offset, counted from the full end. While master reset is high it captures a three-bit select code and a parity option. The select code either installs one of five fixed offsets in both registers, or arms one of two loading methods.

In the word-load method the next two accepted writes on the write port carry the offsets. In the bit-stream method the offsets arrive one bit per clock on a serial input. Until loading finishes, writes are held back from the FIFO. A done output then rises and stays high until the next master reset. Partial reset, which flushes the FIFO, leaves the captured method, the offsets and the load progress untouched.

The offset width is log2 of the FIFO depth. The data bus must be at least one bit wider than the offset.

Top module: `almostOfsCfg`

## Requirements
- R1: A master reset with select code 0, 1, 2, 3 or 4 sets both offsets to 8, 16, 64, 256 or 1024 respectively, saturated at 2^W-1 for offset width W. It also sets progDone high. Outputs take the new values on the clock edge that samples masterRst high.
- R2: A master reset with code 5 arms bit-stream loading, and codes 6 or 7 arm word loading. In both cases the offsets are cleared to 0 and progDone is low.
- R3: In word-load mode, while progDone is low, the first accepted write loads aeOffset and the second loads afOffset. progDone rises on the edge of the second write. serEn has no effect in this mode.
- R4: With parityMode low at master reset, a loaded offset is wrData[W-1:0]. With parityMode high, wrData bit 8 is skipped: offset bits 7..0 come from wrData[7:0], and offset bit i (for i of 8 or more) comes from wrData[i+1].
- R5: In bit-stream mode, each clock with serEn high and progDone low consumes serData. The first W bits form aeOffset, LSB first, and the next W bits form afOffset, LSB first. Both offsets and progDone update together on the edge of bit 2W. Clocks with serEn low consume nothing, and wrEn is not a load in this mode.
- R6: fifoWrEn equals wrEn while progDone is high and masterRst is low. It is 0 otherwise, so programming writes are never forwarded.
- R7: While partialRst is high, offsets, progDone and load progress do not change, and no write or serial bit is consumed.
- R8: Once progDone is high, further writes and serial bits leave both offsets unchanged.
- R9: A master reset during an unfinished load discards it and applies the newly sampled code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| masterRst | input | 1 | Synchronous master reset, samples selCode and parityMode |
| partialRst | input | 1 | Synchronous partial reset (FIFO flush), freezes this unit |
| selCode | input | 3 | Offset source select, sampled during master reset |
| parityMode | input | 1 | Skip data bit 8 on word loads, sampled during master reset |
| wrEn | input | 1 | Write strobe on the write port |
| wrData | input | DATA_W | Write data |
| serEn | input | 1 | Serial bit valid |
| serData | input | 1 | Serial offset bit |
| aeOffset | output | log2(DEPTH) | Almost-empty offset |
| afOffset | output | log2(DEPTH) | Almost-full offset |
| progDone | output | 1 | Offsets are final |
| fifoWrEn | output | 1 | Write strobe forwarded to the FIFO |

## Verification
The hardest situation to reach is a partial reset that lands in the middle of a load, where a half-assembled bit-stream or a pending second word must survive unchanged. The bench stalls each load part-way with partialRst high while presenting junk writes and serial bits. It then finishes the load and compares against offsets computed from only the legitimate stimulus. Word loads are swept over arithmetic data patterns in both parity settings, and bit-stream loads over arithmetic offset pairs, with serEn gaps that carry inverted bits.

// File: rtl/ofsCfgPkg.sv
package ofsCfgPkg;

  typedef enum logic [1:0] {
    MODE_FIXED    = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2
  } progMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadReset;   // master reset cycle: install reset value
    logic [2:0] resetCode;   // code sampled in that cycle
    logic       loadAe;      // word load into almost-empty offset
    logic       loadAf;      // word load into almost-full offset
    logic       shiftIn;     // consume one serial bit
    logic       shiftBit;    // the serial bit
    logic       commit;      // last serial bit: move shift register to offsets
    logic       parityOn;    // skip data bit 8 on word loads
  } ofsStrobe_t;

  function automatic progMode_e decodeMode(input logic [2:0] code);
    if (code <= 3'd4)      return MODE_FIXED;
    else if (code == 3'd5) return MODE_SERIAL;
    else                   return MODE_PARALLEL;
  endfunction

  function automatic int unsigned fixedOffset(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 64;
      3'd3:    return 256;
      3'd4:    return 1024;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofsCtrl.sv
module ofsCtrl
  import ofsCfgPkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic       clk,
  input  logic       masterRst,
  input  logic       partialRst,
  input  logic [2:0] selCode,
  input  logic       parityMode,
  input  logic       wrEn,
  input  logic       serEn,
  input  logic       serData,
  output ofsStrobe_t strb,
  output logic       progDone,
  output logic       fifoWrEn
);

  localparam int BITS  = 2 * OFS_W;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  progMode_e        modeQ;
  logic             parityQ;
  logic             doneQ;
  logic             aeTaken;
  logic [CNT_W-1:0] serCnt;

  logic accept;
  logic loadAe, loadAf, shiftIn, lastShift;

  // A load step may happen only outside both resets and before completion
  assign accept    = !masterRst && !partialRst && !doneQ;
  assign loadAe    = accept && (modeQ == MODE_PARALLEL) && wrEn && !aeTaken;
  assign loadAf    = accept && (modeQ == MODE_PARALLEL) && wrEn &&  aeTaken;
  assign shiftIn   = accept && (modeQ == MODE_SERIAL) && serEn;
  assign lastShift = shiftIn && (serCnt == LAST);

  always_ff @(posedge clk) begin
    if (masterRst) begin
      modeQ   <= decodeMode(selCode);
      parityQ <= parityMode;
      doneQ   <= (decodeMode(selCode) == MODE_FIXED);
      aeTaken <= 1'b0;
      serCnt  <= '0;
    end else begin
      if (loadAe)                 aeTaken <= 1'b1;
      if (shiftIn && !lastShift)  serCnt  <= serCnt + CNT_W'(1);
      if (loadAf || lastShift)    doneQ   <= 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadReset = masterRst;
    strb.resetCode = selCode;
    strb.loadAe    = loadAe;
    strb.loadAf    = loadAf;
    strb.shiftIn   = shiftIn;
    strb.shiftBit  = serData;
    strb.commit    = lastShift;
    strb.parityOn  = parityQ;
  end

  assign progDone = doneQ;
  assign fifoWrEn = wrEn && doneQ && !masterRst;

  // Assertions
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (masterRst)
    doneQ |=> doneQ);                                                     // R8
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (masterRst)
    $onehot0({loadAe, loadAf, shiftIn}));                                 // R3
  AST_PRS_FREEZE: assert property (@(posedge clk) disable iff (masterRst)
    partialRst |=> $stable(doneQ) && $stable(aeTaken) && $stable(serCnt)); // R7
  AST_SER_BOUND: assert property (@(posedge clk) disable iff (masterRst)
    serCnt <= LAST);                                                      // R5
  AST_NO_FWD_PROG: assert property (@(posedge clk) disable iff (masterRst)
    (loadAe || loadAf || shiftIn) |-> !fifoWrEn);                         // R6

endmodule

// File: rtl/ofsData.sv
module ofsData
  import ofsCfgPkg::*;
#(
  parameter int OFS_W  = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  ofsStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFS_W-1:0]  aeOfs,
  output logic [OFS_W-1:0]  afOfs
);

  localparam int          BITS    = 2 * OFS_W;
  localparam int unsigned OFS_MAX = (1 << OFS_W) - 1;

  logic [OFS_W-1:0] busField;
  logic [OFS_W-1:0] rstVal;
  logic [BITS-1:0]  shiftReg;
  logic [BITS-1:0]  shiftNext;

  // Bus field extraction: parity skips bit 8 and upper bits close the gap
  for (genvar i = 0; i < OFS_W; i++) begin : g_field
    if (i < 8) begin : g_low
      assign busField[i] = wrData[i];
    end else begin : g_high
      assign busField[i] = strb.parityOn ? wrData[i+1] : wrData[i];
    end
  end

  if (DATA_W > OFS_W + 1) begin : g_spare
    logic unusedHigh;
    assign unusedHigh = ^wrData[DATA_W-1:OFS_W+1];
  end

  // Reset value: fixed offset saturated to the register range
  always_comb begin
    int unsigned raw;
    raw    = fixedOffset(strb.resetCode);
    rstVal = (raw > OFS_MAX) ? OFS_W'(OFS_MAX) : OFS_W'(raw);
  end

  // Right shift, new bit at the top: after 2W bits the first W sit low
  assign shiftNext = {strb.shiftBit, shiftReg[BITS-1:1]};

  always_ff @(posedge clk) begin
    if (strb.loadReset) begin
      aeOfs    <= rstVal;
      afOfs    <= rstVal;
      shiftReg <= '0;
    end else begin
      if (strb.shiftIn) shiftReg <= shiftNext;
      if (strb.commit) begin
        aeOfs <= shiftNext[OFS_W-1:0];
        afOfs <= shiftNext[BITS-1:OFS_W];
      end
      if (strb.loadAe) aeOfs <= busField;
      if (strb.loadAf) afOfs <= busField;
    end
  end

  AST_AE_KEPT_ON_AF: assert property (@(posedge clk) disable iff (strb.loadReset)
    (strb.loadAf && !strb.commit) |=> $stable(aeOfs));                   // R3
  AST_SER_HIDDEN: assert property (@(posedge clk) disable iff (strb.loadReset)
    (strb.shiftIn && !strb.commit) |=> $stable(aeOfs) && $stable(afOfs)); // R5

endmodule

// File: rtl/almostOfsCfg.sv
module almostOfsCfg
  import ofsCfgPkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 36
) (
  input  logic                     clk,
  input  logic                     masterRst,
  input  logic                     partialRst,
  input  logic [2:0]               selCode,
  input  logic                     parityMode,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     serEn,
  input  logic                     serData,
  output logic [$clog2(DEPTH)-1:0] aeOffset,
  output logic [$clog2(DEPTH)-1:0] afOffset,
  output logic                     progDone,
  output logic                     fifoWrEn
);

  localparam int OFS_W = $clog2(DEPTH);

  ofsStrobe_t strb;

  ofsCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk        (clk),
    .masterRst  (masterRst),
    .partialRst (partialRst),
    .selCode    (selCode),
    .parityMode (parityMode),
    .wrEn       (wrEn),
    .serEn      (serEn),
    .serData    (serData),
    .strb       (strb),
    .progDone   (progDone),
    .fifoWrEn   (fifoWrEn)
  );

  ofsData #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .strb   (strb),
    .wrData (wrData),
    .aeOfs  (aeOffset),
    .afOfs  (afOffset)
  );

  AST_PRS_KEEP_OFS: assert property (@(posedge clk) disable iff (masterRst)
    partialRst |=> $stable(aeOffset) && $stable(afOffset));              // R7

endmodule

// File: tb/almostOfsCfg_bench.sv
module almostOfsCfg_bench;

  localparam int DEPTH  = 512;
  localparam int DATA_W = 12;
  localparam int W      = 9;

  logic              clk = 1'b0;
  logic              masterRst = 1'b1;
  logic              partialRst = 1'b0;
  logic [2:0]        selCode = 3'd0;
  logic              parityMode = 1'b0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              serEn = 1'b0;
  logic              serData = 1'b0;
  logic [W-1:0]      aeOffset, afOffset;
  logic              progDone, fifoWrEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  almostOfsCfg #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_almostOfsCfg (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .selCode(selCode), .parityMode(parityMode), .wrEn(wrEn), .wrData(wrData),
    .serEn(serEn), .serData(serData), .aeOffset(aeOffset), .afOffset(afOffset),
    .progDone(progDone), .fifoWrEn(fifoWrEn)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fixedExp(input int code);
    int v;
    case (code)
      0: v = 8;  1: v = 16;  2: v = 64;  3: v = 256;  4: v = 1024;
      default: v = 0;
    endcase
    return (v > DEPTH - 1) ? DEPTH - 1 : v;
  endfunction

  function automatic int busExp(input int d, input bit par);
    if (par) return ((((d >> 9) << 8) | (d & 255)) & (DEPTH - 1));
    return d & (DEPTH - 1);
  endfunction

  task automatic doReset(input int code, input bit par);
    @(negedge clk);
    masterRst = 1'b1; selCode = 3'(code); parityMode = par;
    wrEn = 1'b0; serEn = 1'b0; partialRst = 1'b0;
    @(negedge clk);
    masterRst = 1'b0; selCode = 3'(7 - code);  // ignored outside reset
  endtask

  // One write cycle; checks forwarding before the edge
  task automatic doWrite(input int d, input int expFwd, input string req);
    wrEn = 1'b1; wrData = DATA_W'(d);
    #1 check(req, fifoWrEn, expFwd);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic serBit(input bit b);
    serEn = 1'b1; serData = b;
    @(negedge clk);
    serEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    masterRst = 1'b0;
    // reset state after the initial master reset with code 0
    check("R1 initial ae", aeOffset, 8);
    check("R1 initial done", progDone, 1);

    // R1 / R2: all codes, both parity settings
    for (int code = 0; code < 8; code++) begin
      for (int p = 0; p < 2; p++) begin
        doReset(code, p[0]);
        check(code < 5 ? "R1 ae" : "R2 ae", aeOffset, fixedExp(code));
        check(code < 5 ? "R1 af" : "R2 af", afOffset, fixedExp(code));
        check(code < 5 ? "R1 done" : "R2 done", progDone, code < 5 ? 1 : 0);
      end
    end

    // R3 / R4 / R6 / R8: word loads swept over patterns
    for (int k = 0; k < 48; k++) begin
      for (int p = 0; p < 2; p++) begin
        int d1, d2;
        d1 = (k * 337 + 11) % 4096;
        d2 = (k * 1013 + 2047) % 4096;
        doReset(6 + (k % 2), p[0]);
        serBit(1'b1);  // no effect in word mode
        check("R3 serEn ignored", progDone, 0);
        doWrite(d1, 0, "R6 first load not forwarded");
        check("R4 ae field", aeOffset, busExp(d1, p[0]));
        check("R3 af still clear", afOffset, 0);
        check("R3 done low after one", progDone, 0);
        doWrite(d2, 0, "R6 second load not forwarded");
        check("R4 af field", afOffset, busExp(d2, p[0]));
        check("R3 done", progDone, 1);
        doWrite(~d1 & 4095, 1, "R6 forwarded after done");
        check("R8 ae kept", aeOffset, busExp(d1, p[0]));
        check("R8 af kept", afOffset, busExp(d2, p[0]));
      end
    end

    // R5: bit-stream loads with gaps carrying inverted bits
    for (int k = 0; k < 24; k++) begin
      int ae, af;
      ae = (k * 53 + 1) % DEPTH;
      af = (k * 97 + 300) % DEPTH;
      doReset(5, k[0]);
      for (int i = 0; i < 2 * W; i++) begin
        bit b;
        b = (i < W) ? ae[i] : af[i - W];
        if (i == 4 || i == W + 2) begin
          serEn = 1'b0; serData = ~b; wrEn = 1'b1; wrData = 12'hFFF;
          #1 check("R5 wrEn not forwarded", fifoWrEn, 0);
          @(negedge clk);
          wrEn = 1'b0;
        end
        if (i == 2 * W - 1) check("R5 done before last bit", progDone, 0);
        if (i == 2 * W - 1) check("R5 ae hidden before last", aeOffset, 0);
        serBit(b);
      end
      check("R5 ae", aeOffset, ae);
      check("R5 af", afOffset, af);
      check("R5 done", progDone, 1);
      serBit(1'b1); serBit(1'b0);
      check("R8 ae after extra bits", aeOffset, ae);
      check("R8 af after extra bits", afOffset, af);
    end

    // R7: partial reset in the middle of a word load
    doReset(6, 1'b1);
    doWrite(12'hA5C, 0, "R6 load");
    partialRst = 1'b1;
    doWrite(12'h3FF, 0, "R7 write during partial reset");
    partialRst = 1'b0;
    check("R7 af untouched", afOffset, 0);
    check("R7 done untouched", progDone, 0);
    check("R7 ae untouched", aeOffset, busExp(12'hA5C, 1'b1));
    doWrite(12'h123, 0, "R6 load");
    check("R7 af after resume", afOffset, busExp(12'h123, 1'b1));
    check("R7 ae after resume", aeOffset, busExp(12'hA5C, 1'b1));

    // R7: partial reset in the middle of a bit-stream
    doReset(5, 1'b0);
    for (int i = 0; i < 2 * W; i++) begin
      int val;
      val = (i < W) ? 9'h155 : 9'h0F3;
      if (i == 7) begin
        partialRst = 1'b1;
        serBit(~val[i % W]);
        serBit(~val[i % W]);
        partialRst = 1'b0;
      end
      serBit(val[i % W]);
    end
    check("R7 serial ae", aeOffset, 9'h155);
    check("R7 serial af", afOffset, 9'h0F3);

    // R7: partial reset after a fixed setting
    doReset(3, 1'b0);
    partialRst = 1'b1;
    @(negedge clk); @(negedge clk);
    partialRst = 1'b0;
    check("R7 fixed ae kept", aeOffset, 256);
    check("R7 fixed done kept", progDone, 1);

    // R9: master reset during an unfinished load
    doReset(7, 1'b0);
    doWrite(12'h0AB, 0, "R6 load");
    doReset(2, 1'b0);
    check("R9 ae", aeOffset, 64);
    check("R9 af", afOffset, 64);
    check("R9 done", progDone, 1);
    doReset(5, 1'b0);
    serBit(1'b1); serBit(1'b1);
    doReset(6, 1'b0);
    check("R9 restart done low", progDone, 0);
    doWrite(12'h00F, 0, "R6 load");
    check("R9 word ae", aeOffset, 15);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule